// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

The engine walks a chain of descriptors held in system memory and moves data between a block buffer and memory as each descriptor directs. One engine understands three descriptor layouts, picked by a format input: a one-word compact layout, a two-word layout with 32-bit addresses and a three-word layout with 64-bit addresses. Each descriptor carries an action (no-op, transfer or link), an END flag and an interrupt flag. Data moves in 32-bit words. A block fill count runs across descriptor boundaries, so a block may be split over several descriptors. An optional block count ends the walk once the last block is complete.

Software loads the descriptor pointer and block count with `cfg_load` while the engine is idle, then pulses `start` once per service slice. A slice handles at most `MAX_DESC` descriptors. It also ends early on an interrupt pause, a memory error or completion. The pointer, the block count and the fill count are kept across slices, so the next `start` resumes where the last slice stopped.

The memory port is a request/response pair. A request stays valid, with address, direction and write data held, until `mem_req_ready` is seen. Only one request is outstanding at a time. The response is a single-cycle `mem_rsp_valid` pulse carrying read data and an error flag, and the engine always accepts it. Both buffer ports are valid/ready. The engine holds `buf_out_valid` and `buf_out_data` stable until `buf_out_ready`. It raises `buf_in_ready` only while it is waiting for the next word to write to memory.

Top module: `adma_engine`

## Requirements
- R1: Format 0 (compact) reads one word per descriptor. The attribute is word bits 6:0, the data address is bits 31:12 with the low 12 address bits zero, and a transfer moves `A1_LEN` bytes. The pointer steps by 4.
- R2: Format 1 reads two words. Word 0 holds the attribute in bits 7:0 and the byte length in bits 31:16. Word 1 is the 32-bit data address. The pointer steps by 8.
- R3: Formats 2 and 3 read three words. Word 0 holds the attribute in bits 5:0 (bits 7:6 are ignored) and the length in bits 31:16. Words 1 and 2 are the low and high halves of a 64-bit data address. The pointer steps by 12.
- R4: The attribute has END at bit 1, interrupt at bit 2 and the action in bits 5:4: 2'b10 is transfer, 2'b11 is link, and 2'b00 or 2'b01 is a no-op. A link loads the pointer from the address field. Every other action advances the pointer by the format step.
- R5: If block counting is enabled and the block count is zero when `start` arrives, the transfer ends (`xfer_done` pulses) and no memory request is made.
- R6: A transfer action sets `sts_inhibit` and `sts_line_active`, plus `sts_rd_active` when `dir_to_mem`=1 (buffer to memory) or `sts_wr_active` otherwise. All four clear when the transfer ends.
- R7: Each word moved adds 4 bytes to a block fill count that carries over between descriptors. When the count reaches `blk_size`, it wraps to zero and, if counting is enabled, the block count drops by one. Lengths count whole words (bits 1:0 ignored).
- R8: The walk ends, with a one-cycle `xfer_done` and `busy` low, after a descriptor with END set or once the block count reaches zero. A zero count stops data movement mid-descriptor, and the pointer still steps past that descriptor.
- R9: An error response stops the walk and leaves the pointer unchanged. When `err_irq_en`=1, `sts_adma_err` and `sts_err_summary` set and `irq` rises. When `err_irq_en`=0, no flag changes.
- R10: A descriptor with the interrupt flag set, processed while `dma_irq_en`=1, sets `sts_dma_int` and raises `irq`. If its END bit is clear, the slice pauses after that descriptor and the next `start` continues from the following one. With `dma_irq_en`=0 the flag has no effect.
- R11: One slice processes at most `MAX_DESC` descriptors, then `busy` drops with the pointer at the next descriptor.
- R12: `mem_req_valid` with its address, direction and data, and `buf_out_valid` with its data, stay stable until accepted.
- R13: `irq` is a level equal to `sts_adma_err | sts_dma_int`. `clr_status` clears both of these and `sts_err_summary`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one service slice (idle only) |
| cfg_load | input | 1 | Load pointer and block count, clear fill count (idle only) |
| cfg_ptr | input | 64 | Descriptor pointer to load |
| cfg_blk_cnt | input | CNT_W | Block count to load |
| fmt | input | 2 | Descriptor format: 0 compact, 1 two-word, 2/3 three-word |
| dir_to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| blk_cnt_en | input | 1 | Enable block counting |
| blk_size | input | BSZ_W | Block size in bytes (multiple of 4) |
| err_irq_en | input | 1 | Enable error flags |
| dma_irq_en | input | 1 | Enable descriptor interrupt and pause |
| clr_status | input | 1 | Clear interrupt-related flags |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 64 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response pulse |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_rdata | input | 32 | Read data |
| buf_in_valid | input | 1 | Buffer word available (toward memory) |
| buf_in_ready | output | 1 | Engine takes buffer word |
| buf_in_data | input | 32 | Buffer word |
| buf_out_valid | output | 1 | Word for the buffer valid |
| buf_out_ready | input | 1 | Buffer accepts word |
| buf_out_data | output | 32 | Word for the buffer |
| busy | output | 1 | Slice in progress |
| xfer_done | output | 1 | One-cycle pulse at transfer end |
| desc_ptr | output | 64 | Current descriptor pointer |
| blk_cnt | output | CNT_W | Remaining block count |
| sts_inhibit | output | 1 | Data inhibit status |
| sts_line_active | output | 1 | Data line active status |
| sts_rd_active | output | 1 | Buffer-to-memory transfer active |
| sts_wr_active | output | 1 | Memory-to-buffer transfer active |
| sts_adma_err | output | 1 | Descriptor DMA error flag |
| sts_err_summary | output | 1 | Error summary flag |
| sts_dma_int | output | 1 | Descriptor interrupt flag |
| irq | output | 1 | Interrupt level |

## Verification
The walk is tried with each of the three layouts. A two-word chain moving memory to buffer shows the step of 8 and plain END handling. A three-word chain with a link and a block split across descriptors, moving buffer to memory, separates fill carry-over from count-driven termination mid-descriptor. A compact chain with a link confirms the 4 KiB-aligned address field. The remaining patterns are a run of no-op descriptors, which shows where a slice yields; an interrupt-flagged descriptor with the enable on and off, which separates a pause from a pass-through; an injected memory error with error flags enabled and disabled, which tests the pointer freeze and the flag gating; and a zero block count at entry. All of them run while both memory and buffer apply back-pressure.

// File: rtl/adma_pkg.sv
package adma_pkg;
  typedef enum logic [1:0] {
    FMT_COMPACT = 2'd0,
    FMT_W32     = 2'd1,
    FMT_W64     = 2'd2,
    FMT_W64B    = 2'd3
  } fmt_e;

  localparam logic [1:0] ACT_TRAN = 2'b10;
  localparam logic [1:0] ACT_LINK = 2'b11;

  localparam int ATTR_END = 1;
  localparam int ATTR_INT = 2;

  typedef struct packed {
    logic [7:0]  attr;
    logic [15:0] len;
    logic [63:0] addr;
    logic [3:0]  step;
    logic [1:0]  nwords;
  } desc_t;
endpackage

// File: rtl/adma_desc_decode.sv
module adma_desc_decode
  import adma_pkg::*;
#(
  parameter int A1_LEN = 4096
) (
  input  logic [1:0]  fmt,
  input  logic [31:0] w0,
  input  logic [31:0] w1,
  input  logic [31:0] w2,
  output desc_t       dsc
);
  localparam logic [15:0] A1_LEN_L = 16'(A1_LEN);

  logic unused_w0;
  assign unused_w0 = ^w0[15:8];

  always_comb begin
    dsc = '0;
    unique case (fmt_e'(fmt))
      FMT_COMPACT: begin
        dsc.attr   = {1'b0, w0[6:0]};
        dsc.len    = A1_LEN_L;
        dsc.addr   = {32'h0, w0[31:12], 12'h000};
        dsc.step   = 4'd4;
        dsc.nwords = 2'd1;
      end
      FMT_W32: begin
        dsc.attr   = w0[7:0];
        dsc.len    = w0[31:16];
        dsc.addr   = {32'h0, w1};
        dsc.step   = 4'd8;
        dsc.nwords = 2'd2;
      end
      default: begin
        dsc.attr   = {2'b00, w0[5:0]};
        dsc.len    = w0[31:16];
        dsc.addr   = {w2, w1};
        dsc.step   = 4'd12;
        dsc.nwords = 2'd3;
      end
    endcase
  end
endmodule

// File: rtl/adma_blk_tracker.sv
module adma_blk_tracker #(
  parameter int CNT_W = 16,
  parameter int BSZ_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             cnt_en,
  input  logic [BSZ_W-1:0] blk_size,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero,
  output logic             last_word
);
  localparam int FW = BSZ_W + 1;

  logic [FW-1:0] fill;
  logic [FW-1:0] fill_next;
  logic          blk_full;

  assign fill_next = fill + FW'(4);
  assign blk_full  = fill_next >= {1'b0, blk_size};
  assign cnt_zero  = (cnt == '0);
  assign last_word = cnt_en && blk_full && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      cnt  <= '0;
    end else if (load) begin
      fill <= '0;
      cnt  <= load_cnt;
    end else if (step) begin
      if (blk_full) begin
        fill <= '0;
        if (cnt_en && !cnt_zero) cnt <= cnt - CNT_W'(1);
      end else begin
        fill <= fill_next;
      end
    end
  end

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(blk_size) && blk_size != '0 && blk_size[1:0] == 2'b00) |-> (fill < {1'b0, blk_size}));

  p_cnt_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_en && blk_full && !cnt_zero) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/adma_engine.sv
module adma_engine
  import adma_pkg::*;
#(
  parameter int MAX_DESC = 5,
  parameter int CNT_W    = 16,
  parameter int BSZ_W    = 12,
  parameter int A1_LEN   = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_load,
  input  logic [63:0]      cfg_ptr,
  input  logic [CNT_W-1:0] cfg_blk_cnt,
  input  logic [1:0]       fmt,
  input  logic             dir_to_mem,
  input  logic             blk_cnt_en,
  input  logic [BSZ_W-1:0] blk_size,
  input  logic             err_irq_en,
  input  logic             dma_irq_en,
  input  logic             clr_status,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [63:0]      mem_req_addr,
  output logic [31:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [31:0]      mem_rsp_rdata,
  input  logic             buf_in_valid,
  output logic             buf_in_ready,
  input  logic [31:0]      buf_in_data,
  output logic             buf_out_valid,
  input  logic             buf_out_ready,
  output logic [31:0]      buf_out_data,
  output logic             busy,
  output logic             xfer_done,
  output logic [63:0]      desc_ptr,
  output logic [CNT_W-1:0] blk_cnt,
  output logic             sts_inhibit,
  output logic             sts_line_active,
  output logic             sts_rd_active,
  output logic             sts_wr_active,
  output logic             sts_adma_err,
  output logic             sts_err_summary,
  output logic             sts_dma_int,
  output logic             irq
);
  localparam int SLC_W = $clog2(MAX_DESC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_EXEC, S_DGET, S_DREQ,
    S_DWAIT, S_DPUSH, S_DSTEP, S_NEXT, S_FIN
  } st_e;

  st_e              state;
  logic [31:0]      wbuf [3];
  logic [1:0]       widx;
  logic [SLC_W-1:0] slice_cnt;
  logic [63:0]      xaddr;
  logic [15:0]      xrem;
  logic [31:0]      dword;
  desc_t            dsc;
  logic             cnt_zero;
  logic             last_word;
  logic             step;
  logic             rsp_fail;
  logic             int_take;
  logic [63:0]      ptr_next;
  logic             unused_attr;

  adma_desc_decode #(.A1_LEN(A1_LEN)) u_dec (
    .fmt (fmt),
    .w0  (wbuf[0]),
    .w1  (wbuf[1]),
    .w2  (wbuf[2]),
    .dsc (dsc)
  );

  adma_blk_tracker #(.CNT_W(CNT_W), .BSZ_W(BSZ_W)) u_blk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load && state == S_IDLE),
    .load_cnt  (cfg_blk_cnt),
    .cnt_en    (blk_cnt_en),
    .blk_size  (blk_size),
    .step      (step),
    .cnt       (blk_cnt),
    .cnt_zero  (cnt_zero),
    .last_word (last_word)
  );

  assign unused_attr = ^{dsc.attr[7:6], dsc.attr[3], dsc.attr[0]};

  assign step     = (state == S_DSTEP);
  assign rsp_fail = mem_rsp_valid && mem_rsp_err;
  assign int_take = dsc.attr[ATTR_INT] && dma_irq_en;
  assign ptr_next = (dsc.attr[5:4] == ACT_LINK) ? dsc.addr
                                               : desc_ptr + {60'h0, dsc.step};

  assign busy          = (state != S_IDLE);
  assign mem_req_valid = (state == S_FETCH) || (state == S_DREQ);
  assign mem_req_write = (state == S_DREQ) && dir_to_mem;
  assign mem_req_addr  = (state == S_FETCH) ? desc_ptr + {60'h0, widx, 2'b00} : xaddr;
  assign mem_req_wdata = dword;
  assign buf_in_ready  = (state == S_DGET);
  assign buf_out_valid = (state == S_DPUSH);
  assign buf_out_data  = dword;
  assign irq           = sts_adma_err | sts_dma_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      widx            <= '0;
      slice_cnt       <= '0;
      xaddr           <= '0;
      xrem            <= '0;
      dword           <= '0;
      desc_ptr        <= '0;
      xfer_done       <= 1'b0;
      sts_inhibit     <= 1'b0;
      sts_line_active <= 1'b0;
      sts_rd_active   <= 1'b0;
      sts_wr_active   <= 1'b0;
      sts_adma_err    <= 1'b0;
      sts_err_summary <= 1'b0;
      sts_dma_int     <= 1'b0;
      for (int i = 0; i < 3; i++) wbuf[i] <= '0;
    end else begin
      xfer_done <= (state == S_FIN);
      if (clr_status) begin
        sts_adma_err    <= 1'b0;
        sts_err_summary <= 1'b0;
        sts_dma_int     <= 1'b0;
      end
      if ((state == S_FWAIT || state == S_DWAIT) && rsp_fail && err_irq_en) begin
        sts_adma_err    <= 1'b1;
        sts_err_summary <= 1'b1;
      end

      unique case (state)
        S_IDLE: begin
          if (cfg_load) desc_ptr <= cfg_ptr;
          if (start) begin
            slice_cnt <= '0;
            widx      <= '0;
            state     <= (blk_cnt_en && cnt_zero) ? S_FIN : S_FETCH;
          end
        end
        S_FETCH: if (mem_req_ready) state <= S_FWAIT;
        S_FWAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              state <= S_IDLE;
            end else begin
              wbuf[widx] <= mem_rsp_rdata;
              if (widx == dsc.nwords - 2'd1) begin
                state <= S_EXEC;
              end else begin
                widx  <= widx + 2'd1;
                state <= S_FETCH;
              end
            end
          end
        end
        S_EXEC: begin
          if (dsc.attr[5:4] == ACT_TRAN) begin
            xaddr           <= dsc.addr;
            xrem            <= dsc.len;
            sts_inhibit     <= 1'b1;
            sts_line_active <= 1'b1;
            if (dir_to_mem) sts_rd_active <= 1'b1;
            else            sts_wr_active <= 1'b1;
            if (dsc.len[15:2] == '0) state <= S_NEXT;
            else                     state <= dir_to_mem ? S_DGET : S_DREQ;
          end else begin
            state <= S_NEXT;
          end
        end
        S_DGET: begin
          if (buf_in_valid) begin
            dword <= buf_in_data;
            state <= S_DREQ;
          end
        end
        S_DREQ: if (mem_req_ready) state <= S_DWAIT;
        S_DWAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              state <= S_IDLE;
            end else if (dir_to_mem) begin
              state <= S_DSTEP;
            end else begin
              dword <= mem_rsp_rdata;
              state <= S_DPUSH;
            end
          end
        end
        S_DPUSH: if (buf_out_ready) state <= S_DSTEP;
        S_DSTEP: begin
          xaddr <= xaddr + 64'd4;
          xrem  <= xrem - 16'd4;
          if (last_word || xrem[15:2] == 14'd1) state <= S_NEXT;
          else                                  state <= dir_to_mem ? S_DGET : S_DREQ;
        end
        S_NEXT: begin
          desc_ptr  <= ptr_next;
          slice_cnt <= slice_cnt + SLC_W'(1);
          widx      <= '0;
          if (int_take) sts_dma_int <= 1'b1;
          if (dsc.attr[ATTR_END] || (blk_cnt_en && cnt_zero)) state <= S_FIN;
          else if (int_take)                                   state <= S_IDLE;
          else if (slice_cnt + SLC_W'(1) == SLC_W'(MAX_DESC))  state <= S_IDLE;
          else                                                 state <= S_FETCH;
        end
        S_FIN: begin
          sts_inhibit     <= 1'b0;
          sts_line_active <= 1'b0;
          sts_rd_active   <= 1'b0;
          sts_wr_active   <= 1'b0;
          state           <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  p_out_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_out_valid && !buf_out_ready) |=> (buf_out_valid && $stable(buf_out_data)));

  p_err_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_FWAIT || state == S_DWAIT) && rsp_fail) |=> ($stable(desc_ptr) && !busy));

  p_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_NEXT && dsc.attr[5:4] == ACT_LINK) |=> (desc_ptr == $past(dsc.addr)));

  p_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && blk_cnt_en && cnt_zero) |=> !mem_req_valid);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);

  p_slice_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_NEXT) |-> (slice_cnt < SLC_W'(MAX_DESC)));

  p_irq_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !busy) |=> !irq);
endmodule

// File: tb/tb_adma_engine.sv
`timescale 1ns/1ps
module tb_adma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, cfg_load = 1'b0, clr_status = 1'b0;
  logic [63:0] cfg_ptr = '0;
  logic [15:0] cfg_blk_cnt = '0;
  logic [1:0]  fmt = 2'd1;
  logic        dir_to_mem = 1'b0, blk_cnt_en = 1'b0, err_irq_en = 1'b0, dma_irq_en = 1'b0;
  logic [11:0] blk_size = 12'd16;
  logic        mem_req_valid, mem_req_write, mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_rdata = '0;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic        buf_in_valid = 1'b0, buf_in_ready;
  logic [31:0] buf_in_data = '0;
  logic        buf_out_valid, buf_out_ready = 1'b0;
  logic [31:0] buf_out_data;
  logic        busy, xfer_done, sts_inhibit, sts_line_active, sts_rd_active, sts_wr_active;
  logic        sts_adma_err, sts_err_summary, sts_dma_int, irq;
  logic [63:0] desc_ptr;
  logic [15:0] blk_cnt;

  always #10 clk = ~clk;

  adma_engine #(.A1_LEN(16)) dut (.*);

  int tests = 0, fails = 0, cyc = 0, req_cnt = 0, done_cnt = 0;
  bit [31:0] mem [bit [63:0]];
  logic [63:0] exp_wa [$];
  logic [31:0] exp_wd [$];
  logic [31:0] exp_out [$];
  logic [31:0] src [$];
  bit        pend = 0, pend_err = 0, in_hs = 0, err_on = 0;
  logic [31:0] pend_data = '0;
  logic [63:0] err_addr = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference memory, buffer source and sink, compared every clock
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      mem_rsp_valid = 0; mem_rsp_err = 0;
      if (pend) begin
        mem_rsp_valid = 1; mem_rsp_rdata = pend_data; mem_rsp_err = pend_err; pend = 0;
      end
      mem_req_ready = (cyc % 3) != 2;
      if (mem_req_valid && mem_req_ready) begin
        req_cnt++;
        pend = 1; pend_err = 0;
        if (err_on && mem_req_addr == err_addr) pend_err = 1;
        else if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
          chk("R7 write addr", mem_req_addr, exp_wa.size() > 0 ? exp_wa[0] : 64'hdead);
          chk("R7 write data", mem_req_wdata, exp_wd.size() > 0 ? exp_wd[0] : 32'hdead);
          chk("R6 status to memory", {sts_inhibit, sts_line_active, sts_rd_active, sts_wr_active}, 4'b1110);
          if (exp_wa.size() > 0) begin void'(exp_wa.pop_front()); void'(exp_wd.pop_front()); end
        end else pend_data = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
      end
      if (in_hs && src.size() > 0) void'(src.pop_front());
      buf_in_valid = (src.size() > 0) && ((cyc % 4) != 3);
      buf_in_data  = (src.size() > 0) ? src[0] : 32'h0;
      in_hs = buf_in_valid && buf_in_ready;
      buf_out_ready = (cyc % 5) != 4;
      if (buf_out_valid && buf_out_ready) begin
        chk("R7 buffer word", buf_out_data, exp_out.size() > 0 ? exp_out[0] : 32'hdead);
        chk("R6 status to buffer", {sts_inhibit, sts_line_active, sts_rd_active, sts_wr_active}, 4'b1101);
        if (exp_out.size() > 0) void'(exp_out.pop_front());
      end
      if (xfer_done) done_cnt++;
    end
  end

  task automatic setup(input logic [1:0] f, input bit to_mem, input int bsz, input bit cen,
                       input int cnt, input logic [63:0] ptr, input bit ie, input bit ee);
    @(negedge clk);
    fmt = f; dir_to_mem = to_mem; blk_size = 12'(bsz); blk_cnt_en = cen;
    cfg_blk_cnt = 16'(cnt); cfg_ptr = ptr; dma_irq_en = ie; err_irq_en = ee; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
    req_cnt = 0; done_cnt = 0;
  endtask

  task automatic go();
    int n = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk("R8 slice ends", 1, 0);
    @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk); clr_status = 1; @(negedge clk); clr_status = 0; @(negedge clk);
  endtask

  function automatic void d32(input logic [63:0] b, input logic [7:0] at, input int len, input logic [31:0] a);
    mem[b] = {16'(len), 8'h00, at}; mem[b+4] = a;
  endfunction
  function automatic void d64(input logic [63:0] b, input logic [7:0] at, input int len, input logic [63:0] a);
    mem[b] = {16'(len), 8'h00, at}; mem[b+4] = a[31:0]; mem[b+8] = a[63:32];
  endfunction
  function automatic void d1(input logic [63:0] b, input logic [6:0] at, input logic [31:0] a);
    mem[b] = {a[31:12], 5'b0, at};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 reset irq/flags", {irq, sts_adma_err, sts_err_summary, sts_dma_int, busy}, 5'b0);
    chk("R6 reset status", {sts_inhibit, sts_line_active, sts_rd_active, sts_wr_active}, 4'b0);
    chk("R4 reset pointer", desc_ptr, 64'h0);

    // R2: two-word format, memory to buffer, END on second
    d32(64'h1000, 8'h20, 8, 32'h2000);
    d32(64'h1008, 8'h22, 8, 32'h3000);
    mem[64'h2000] = 32'hA0; mem[64'h2004] = 32'hA1; mem[64'h3000] = 32'hB0; mem[64'h3004] = 32'hB1;
    exp_out = '{32'hA0, 32'hA1, 32'hB0, 32'hB1};
    setup(2'd1, 0, 8, 0, 0, 64'h1000, 0, 0);
    go();
    chk("R2 pointer step 8", desc_ptr, 64'h1010);
    chk("R2 all words out", exp_out.size(), 0);
    chk("R8 done pulse", done_cnt, 1);
    chk("R6 status cleared", {sts_inhibit, sts_line_active, sts_rd_active, sts_wr_active}, 4'b0);

    // R3/R7/R8: three-word format, link, block carry, count stop mid-descriptor
    d64(64'h400, 8'hE0, 12, 64'h1_0000_4000);
    d64(64'h40C, 8'h30, 0, 64'h600);
    d64(64'h600, 8'h20, 24, 64'h5000);
    src = '{32'h10, 32'h11, 32'h12, 32'h13, 32'h14, 32'h15, 32'h16, 32'h17};
    exp_wa = '{64'h1_0000_4000, 64'h1_0000_4004, 64'h1_0000_4008,
               64'h5000, 64'h5004, 64'h5008, 64'h500C, 64'h5010};
    exp_wd = '{32'h10, 32'h11, 32'h12, 32'h13, 32'h14, 32'h15, 32'h16, 32'h17};
    setup(2'd2, 1, 16, 1, 2, 64'h400, 0, 0);
    go();
    chk("R3 pointer after link and step 12", desc_ptr, 64'h60C);
    chk("R7 block count reached zero", blk_cnt, 16'd0);
    chk("R8 count stop, all writes seen", exp_wa.size(), 0);
    chk("R8 done on count", done_cnt, 1);
    chk("R8 no extra buffer word", src.size(), 0);

    // R1: compact format with link (A1_LEN = 16 here)
    d1(64'h100, 7'h30, 32'h7000);
    d1(64'h7000, 7'h22, 32'h8000);
    mem[64'h8000] = 32'hC0; mem[64'h8004] = 32'hC1; mem[64'h8008] = 32'hC2; mem[64'h800C] = 32'hC3;
    exp_out = '{32'hC0, 32'hC1, 32'hC2, 32'hC3};
    setup(2'd0, 0, 16, 0, 0, 64'h100, 0, 0);
    go();
    chk("R1 pointer step 4", desc_ptr, 64'h7004);
    chk("R1 all words out", exp_out.size(), 0);

    // R11: slice limit over no-op descriptors
    for (int i = 0; i < 8; i++) d32(64'hA000 + 64'(8*i), (i == 7) ? 8'h02 : 8'h10, 0, 0);
    setup(2'd1, 0, 16, 0, 0, 64'hA000, 0, 0);
    go();
    chk("R11 pointer after first slice", desc_ptr, 64'hA028);
    chk("R11 no done after first slice", done_cnt, 0);
    chk("R11 fetch count first slice", req_cnt, 10);
    go();
    chk("R11 pointer after second slice", desc_ptr, 64'hA040);
    chk("R11 done after second slice", done_cnt, 1);

    // R10: interrupt pause and resume
    d32(64'hB000, 8'h24, 4, 32'hC100);
    d32(64'hB008, 8'h22, 4, 32'hC104);
    mem[64'hC100] = 32'hD0; mem[64'hC104] = 32'hD1;
    exp_out = '{32'hD0};
    setup(2'd1, 0, 8, 0, 0, 64'hB000, 1, 0);
    go();
    chk("R10 paused pointer", desc_ptr, 64'hB008);
    chk("R10 irq and flag", {irq, sts_dma_int}, 2'b11);
    chk("R10 no done at pause", done_cnt, 0);
    clr();
    chk("R13 clear drops irq", {irq, sts_dma_int}, 2'b00);
    exp_out = '{32'hD1};
    go();
    chk("R10 resumed to end", desc_ptr, 64'hB010);
    chk("R10 resumed word out", exp_out.size(), 0);
    chk("R10 done after resume", done_cnt, 1);
    exp_out = '{32'hD0, 32'hD1};
    setup(2'd1, 0, 8, 0, 0, 64'hB000, 0, 0);
    go();
    chk("R10 no pause when disabled", desc_ptr, 64'hB010);
    chk("R10 irq stays low", irq, 1'b0);
    chk("R10 done in one slice", done_cnt, 1);

    // R9: memory error with flags enabled, then disabled
    d32(64'hD000, 8'h22, 8, 32'hE000);
    err_on = 1; err_addr = 64'hE004;
    src = '{32'h51, 32'h52};
    exp_wa = '{64'hE000}; exp_wd = '{32'h51};
    setup(2'd1, 1, 16, 0, 0, 64'hD000, 0, 1);
    go();
    chk("R9 pointer held", desc_ptr, 64'hD000);
    chk("R9 flags set", {sts_adma_err, sts_err_summary, irq}, 3'b111);
    chk("R9 no done", done_cnt, 0);
    chk("R9 write before error", exp_wa.size(), 0);
    clr();
    src = '{32'h61, 32'h62};
    exp_wa = '{64'hE000}; exp_wd = '{32'h61};
    setup(2'd1, 1, 16, 0, 0, 64'hD000, 0, 0);
    go();
    chk("R9 pointer held, flags off", desc_ptr, 64'hD000);
    chk("R9 no flags when disabled", {sts_adma_err, sts_err_summary, irq}, 3'b000);
    err_on = 0;

    // R5: zero block count at entry
    setup(2'd1, 0, 16, 1, 0, 64'hF000, 0, 0);
    go();
    chk("R5 done without fetch", done_cnt, 1);
    chk("R5 no memory request", req_cnt, 0);
    chk("R5 pointer unchanged", desc_ptr, 64'hF000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule